// File: doc/BRIEF.md
# Serial FPGA configuration loader

This block loads a configuration image into a target FPGA over a bit-serial slave interface. A single start pulse, qualified by a byte count, makes it pulse the target's active-low program line, wait for the target to clear its memory, and confirm that the target's configuration-done line is still low. The image then arrives one byte at a time on a ready/valid stream.

The image begins with a header of unknown length. Bytes are thrown away until the first byte of value 0xFF, which is kept as the first byte sent. From that byte to the end of the count, every byte is shifted out most significant bit first. Each bit is placed on the data line before a configuration clock pulse and held while the clock is high. A fixed number of trailing clock pulses follows, then a final wait, after which the done line is sampled once to decide between success and failure.

All waits are given as parameters in system clock cycles. The outputs show a busy level and two result flags. The result flags hold until the next accepted start.

Top module: `fpga_cfg_loader`

## Requirements
- R1: Out of reset, and again once a load has finished, progN is 1, cclk is 0, din is 0, busy is 0 and inReady is 0.
- R2: A start pulse while idle raises busy on the next cycle and drives progN low for exactly PROG_LOW_CYC cycles before it is released high.
- R3: After progN is released the block waits exactly SETTLE_CYC cycles and then samples doneIn. If doneIn is 1 it sets doneErr and returns to idle without accepting a byte and without a cclk pulse.
- R4: Exactly totalLen bytes are accepted, a byte being accepted in a cycle where inValid and inReady are both 1. Bytes before the first 0xFF are discarded, and that first 0xFF is the first payload byte.
- R5: If no byte equal to 0xFF occurs among the totalLen accepted bytes, including the case totalLen = 0, no payload bit is sent and only the trailing pulses are issued.
- R6: Payload bytes are sent most significant bit first, with one cclk rising edge per bit. din equals the bit at the rising edge and changes only while cclk is low and was low in the previous cycle.
- R7: Every cclk high phase lasts exactly PHASE_CYC cycles, and every cclk low phase between pulses lasts at least PHASE_CYC cycles.
- R8: After the last payload bit, exactly TRAIL_PULSES further cclk pulses are issued with din held at the last bit sent, or at 0 if no bit was sent.
- R9: Exactly FINAL_CYC cycles after the last cclk falling edge, doneIn is sampled. A 1 sets doneOk and a 0 sets doneErr, and din returns to 0 in the same cycle.
- R10: doneOk and doneErr are never 1 together. Both are 0 while busy is 1, and they hold their value after a load until the next accepted start.
- R11: A start pulse while busy is 1 is ignored. The load in progress completes with the same bytes, bits and result, and progN is not pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, acted on only while idle |
| totalLen | input | LEN_W | Number of bytes in the image, header included, captured at start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | The block accepts inData in this cycle |
| doneIn | input | 1 | Configuration-done level from the target |
| progN | output | 1 | Active-low program line to the target |
| cclk | output | 1 | Configuration clock to the target |
| din | output | 1 | Serial configuration data to the target |
| busy | output | 1 | A load is in progress |
| doneOk | output | 1 | The last load ended with doneIn high |
| doneErr | output | 1 | The last load failed, either at the settle check or at the final check |

## Verification
The bench uses small delay parameters and timestamps every edge of progN, cclk, inReady and busy on the falling system clock. Each result is due a fixed number of cycles after the event that causes it. busy is due one cycle after start. The release of progN is due PROG_LOW_CYC cycles after its fall. The first inReady, or an early doneErr, is due SETTLE_CYC cycles after the release. A cclk fall is due PHASE_CYC cycles after its rise. The final flag is due FINAL_CYC cycles after the last cclk fall. The checks compare these distances exactly, so a design that is late or early by one cycle fails. The expected bit stream and the accepted-byte count are worked out in the bench from the image bytes and the length, over a sweep of header lengths, payload lengths and gaps in inValid.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PROG,
    S_SETTLE,
    S_SEARCH,
    S_FETCH,
    S_SETD,
    S_LO,
    S_HI,
    S_TLO,
    S_THI,
    S_FINAL
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic progLo;
    logic progHi;
    logic clrCnt;
    logic take;
    logic setD;
    logic cclkHi;
    logic cclkLo;
    logic dinClr;
  } strobeT;

endpackage

// File: rtl/fcl_datapath.sv
module fcl_datapath
  import fcl_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] totalLen,
  output logic             progN,
  output logic             cclk,
  output logic             din,
  output logic             cntDone,
  output logic             isFF
);

  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] byteCnt;
  logic [7:0]       shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progN   <= 1'b1;
      cclk    <= 1'b0;
      din     <= 1'b0;
      lenReg  <= '0;
      byteCnt <= '0;
      shReg   <= '0;
    end else begin
      if (stb.progLo) progN <= 1'b0;
      else if (stb.progHi) progN <= 1'b1;

      if (stb.clrCnt) begin
        lenReg  <= totalLen;
        byteCnt <= '0;
      end else if (stb.take) begin
        byteCnt <= byteCnt + 1'b1;
      end

      if (stb.take) shReg <= inData;
      else if (stb.setD) shReg <= {shReg[6:0], 1'b0};

      if (stb.setD) din <= shReg[7];
      else if (stb.dinClr) din <= 1'b0;

      if (stb.cclkHi) cclk <= 1'b1;
      else if (stb.cclkLo) cclk <= 1'b0;
    end
  end

  assign cntDone = (byteCnt == lenReg);
  assign isFF    = &inData;

endmodule

// File: rtl/fcl_ctrl.sv
module fcl_ctrl
  import fcl_pkg::*;
#(
  parameter int PROG_LOW_CYC = 4,
  parameter int SETTLE_CYC   = 50,
  parameter int FINAL_CYC    = 100,
  parameter int PHASE_CYC    = 2,
  parameter int TRAIL_PULSES = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   inValid,
  input  logic   doneIn,
  input  logic   cntDone,
  input  logic   isFF,
  output strobeT stb,
  output logic   inReady,
  output logic   busy,
  output logic   doneOk,
  output logic   doneErr
);

  localparam int MAX_A = (PROG_LOW_CYC > SETTLE_CYC) ? PROG_LOW_CYC : SETTLE_CYC;
  localparam int MAX_B = (FINAL_CYC > PHASE_CYC) ? FINAL_CYC : PHASE_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAXC + 1);
  localparam int PW    = $clog2(TRAIL_PULSES + 1);

  stateT          state, stateNext;
  logic [TW-1:0]  timer;
  logic [2:0]     bitCnt;
  logic [PW-1:0]  pulseCnt;
  logic           startAcc, finishOk, finishErr;

  function automatic logic atEnd(input logic [TW-1:0] t, input int n);
    return t == TW'(n - 1);
  endfunction

  always_comb begin
    stateNext = state;
    stb       = '0;
    inReady   = 1'b0;
    startAcc  = 1'b0;
    finishOk  = 1'b0;
    finishErr = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        startAcc   = 1'b1;
        stb.progLo = 1'b1;
        stb.clrCnt = 1'b1;
        stateNext  = S_PROG;
      end
      S_PROG: if (atEnd(timer, PROG_LOW_CYC)) begin
        stb.progHi = 1'b1;
        stateNext  = S_SETTLE;
      end
      S_SETTLE: if (atEnd(timer, SETTLE_CYC)) begin
        if (doneIn) begin
          finishErr = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_SEARCH;
        end
      end
      S_SEARCH: begin
        if (cntDone) stateNext = S_TLO;
        else begin
          inReady = 1'b1;
          if (inValid) begin
            stb.take = 1'b1;
            if (isFF) stateNext = S_SETD;
          end
        end
      end
      S_FETCH: begin
        if (cntDone) stateNext = S_TLO;
        else begin
          inReady = 1'b1;
          if (inValid) begin
            stb.take  = 1'b1;
            stateNext = S_SETD;
          end
        end
      end
      S_SETD: begin
        stb.setD  = 1'b1;
        stateNext = S_LO;
      end
      S_LO: if (atEnd(timer, PHASE_CYC)) begin
        stb.cclkHi = 1'b1;
        stateNext  = S_HI;
      end
      S_HI: if (atEnd(timer, PHASE_CYC)) begin
        stb.cclkLo = 1'b1;
        stateNext  = (bitCnt == 3'd7) ? S_FETCH : S_SETD;
      end
      S_TLO: if (atEnd(timer, PHASE_CYC)) begin
        stb.cclkHi = 1'b1;
        stateNext  = S_THI;
      end
      S_THI: if (atEnd(timer, PHASE_CYC)) begin
        stb.cclkLo = 1'b1;
        stateNext  = (pulseCnt == PW'(TRAIL_PULSES - 1)) ? S_FINAL : S_TLO;
      end
      S_FINAL: if (atEnd(timer, FINAL_CYC)) begin
        finishOk   = doneIn;
        finishErr  = !doneIn;
        stb.dinClr = 1'b1;
        stateNext  = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      bitCnt   <= '0;
      pulseCnt <= '0;
      doneOk   <= 1'b0;
      doneErr  <= 1'b0;
    end else begin
      state <= stateNext;
      timer <= (stateNext != state) ? '0 : timer + 1'b1;

      if (stb.take) bitCnt <= '0;
      else if (stb.cclkLo && state == S_HI) bitCnt <= bitCnt + 1'b1;

      if (stb.clrCnt) pulseCnt <= '0;
      else if (stb.cclkLo && state == S_THI) pulseCnt <= pulseCnt + 1'b1;

      if (startAcc) begin
        doneOk  <= 1'b0;
        doneErr <= 1'b0;
      end else begin
        if (finishOk)  doneOk  <= 1'b1;
        if (finishErr) doneErr <= 1'b1;
      end
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import fcl_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int PROG_LOW_CYC = 4,
  parameter int SETTLE_CYC   = 50,
  parameter int FINAL_CYC    = 100,
  parameter int PHASE_CYC    = 2,
  parameter int TRAIL_PULSES = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             doneIn,
  output logic             progN,
  output logic             cclk,
  output logic             din,
  output logic             busy,
  output logic             doneOk,
  output logic             doneErr
);

  strobeT stb;
  logic   cntDone;
  logic   isFF;

  fcl_ctrl #(
    .PROG_LOW_CYC(PROG_LOW_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .FINAL_CYC   (FINAL_CYC),
    .PHASE_CYC   (PHASE_CYC),
    .TRAIL_PULSES(TRAIL_PULSES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .inValid(inValid),
    .doneIn (doneIn),
    .cntDone(cntDone),
    .isFF   (isFF),
    .stb    (stb),
    .inReady(inReady),
    .busy   (busy),
    .doneOk (doneOk),
    .doneErr(doneErr)
  );

  fcl_datapath #(
    .LEN_W(LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .totalLen(totalLen),
    .progN   (progN),
    .cclk    (cclk),
    .din     (din),
    .cntDone (cntDone),
    .isFF    (isFF)
  );

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic progN,
  input logic cclk,
  input logic din,
  input logic busy,
  input logic doneOk,
  input logic doneErr
);

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneErr));

  // R10
  flags_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!doneOk && !doneErr));

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (progN && !cclk && !din && !inReady));

  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> (busy && !cclk && !inReady));

  // R6
  din_moves_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(din) |-> (!cclk && !$past(cclk)));

  // R6
  din_held_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cclk && $past(cclk)) |-> $stable(din));

  // R4
  ready_no_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (progN && !cclk));

endmodule

bind fpga_cfg_loader fcl_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inReady(inReady),
  .progN  (progN),
  .cclk   (cclk),
  .din    (din),
  .busy   (busy),
  .doneOk (doneOk),
  .doneErr(doneErr)
);

// File: tb/fpga_cfg_loader_tb.sv
`timescale 1ns/1ps
module fpga_cfg_loader_tb;

  localparam int LEN_W  = 8;
  localparam int PROGL  = 3;
  localparam int SETTLE = 5;
  localparam int FINAL  = 4;
  localparam int PHASE  = 2;
  localparam int TRAIL  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] totalLen = '0;
  logic [7:0] inData;
  logic inValid, inReady;
  logic doneIn = 1'b0;
  logic progN, cclk, din, busy, doneOk, doneErr;

  always #2 clk = ~clk;

  fpga_cfg_loader #(
    .LEN_W(LEN_W), .PROG_LOW_CYC(PROGL), .SETTLE_CYC(SETTLE),
    .FINAL_CYC(FINAL), .PHASE_CYC(PHASE), .TRAIL_PULSES(TRAIL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .totalLen(totalLen),
    .inData(inData), .inValid(inValid), .inReady(inReady), .doneIn(doneIn),
    .progN(progN), .cclk(cclk), .din(din), .busy(busy),
    .doneOk(doneOk), .doneErr(doneErr)
  );

  int checks = 0;
  int fails = 0;

  logic [7:0] mem [0:15];
  int idx = 0;
  int srcN = 0;
  bit clrIdx = 0;
  bit gapMode = 0;
  int doneMode = 0;
  int expBits = 0;
  logic expStream [0:127];
  logic capBits [0:127];

  int cyc = 0;
  logic prevC = 1'b0, prevP = 1'b1, hiDin = 1'b0;
  int pulses, minHi, minLo, loStart, hiStart, dinBad;
  int firstReadyCyc, endCyc, lastFallCyc, progFallCyc, progRiseCyc, progLowW, progFalls;
  bit seenBusy;

  assign inData  = (idx < 16) ? mem[idx] : 8'h00;
  assign inValid = (idx < srcN) && !(gapMode && (cyc % 2 == 1));

  always @(posedge clk) begin
    if (clrIdx) idx <= 0;
    else if (inValid && inReady) idx <= idx + 1;
  end

  // monitor on the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cclk && !prevC) begin
      if (pulses < 128) capBits[pulses] = din;
      pulses = pulses + 1;
      hiDin = din;
      if (loStart >= 0 && cyc - loStart < minLo) minLo = cyc - loStart;
      hiStart = cyc;
    end
    if (!cclk && prevC) begin
      if (cyc - hiStart < minHi) minHi = cyc - hiStart;
      lastFallCyc = cyc;
      loStart = cyc;
    end
    if (cclk && din !== hiDin) dinBad = dinBad + 1;
    if (!progN && prevP) begin progFallCyc = cyc; progFalls = progFalls + 1; end
    if (progN && !prevP) begin progLowW = cyc - progFallCyc; progRiseCyc = cyc; end
    if (inReady && firstReadyCyc < 0) firstReadyCyc = cyc;
    if (busy) seenBusy = 1;
    if (seenBusy && !busy && endCyc < 0) endCyc = cyc;
    doneIn = (doneMode == 1) || (doneMode == 2 && pulses >= expBits + TRAIL);
    prevC = cclk;
    prevP = progN;
    if (cyc == 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not end, actual cycle %0d expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runLoad(input int lenArg, input int mode, input bit gaps,
                         input bit poke, input string tag);
    int ffPos, guard, mism, nPulse;
    logic lastBit;
    ffPos = -1;
    for (int k = 0; k < lenArg; k++) if (ffPos < 0 && mem[k] == 8'hFF) ffPos = k;
    expBits = (ffPos < 0) ? 0 : 8 * (lenArg - ffPos);
    for (int b = 0; b < expBits; b++) expStream[b] = mem[ffPos + b / 8][7 - b % 8];
    lastBit = (expBits > 0) ? expStream[expBits-1] : 1'b0;
    for (int t = 0; t < TRAIL; t++) expStream[expBits + t] = lastBit;

    @(negedge clk);
    pulses = 0; minHi = 1 << 20; minLo = 1 << 20; loStart = -1; hiStart = 0;
    dinBad = 0; firstReadyCyc = -1; endCyc = -1; lastFallCyc = -1;
    progLowW = -1; progFalls = 0; seenBusy = 0;
    doneMode = mode; gapMode = gaps; srcN = lenArg + 2; clrIdx = 1;
    start = 1; totalLen = lenArg[LEN_W-1:0];
    @(negedge clk);
    start = 0; clrIdx = 0;
    chk(busy == 1, "R2", {tag, " busy after start"}, busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; totalLen = '0;
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);

    chk(progLowW == PROGL, "R2", {tag, " program low width"}, progLowW, PROGL);
    chk(progFalls == 1, "R11", {tag, " program pulses"}, progFalls, 1);
    if (mode == 1) begin
      chk(endCyc - progRiseCyc == SETTLE, "R3", {tag, " error delay"}, endCyc - progRiseCyc, SETTLE);
      chk(idx == 0, "R3", {tag, " bytes taken"}, idx, 0);
      chk(pulses == 0, "R3", {tag, " cclk pulses"}, pulses, 0);
      chk(doneErr == 1 && doneOk == 0, "R3", {tag, " error flag"}, doneErr, 1);
    end else begin
      if (lenArg > 0)
        chk(firstReadyCyc - progRiseCyc == SETTLE, "R3", {tag, " settle wait"},
            firstReadyCyc - progRiseCyc, SETTLE);
      chk(idx == lenArg, "R4", {tag, " bytes taken"}, idx, lenArg);
      nPulse = expBits + TRAIL;
      chk(pulses == nPulse, (expBits == 0) ? "R5" : "R8", {tag, " pulse count"}, pulses, nPulse);
      mism = 0;
      for (int b = 0; b < nPulse && b < pulses; b++) if (capBits[b] !== expStream[b]) mism++;
      chk(mism == 0, "R6", {tag, " bit stream msb first with trailer"}, mism, 0);
      chk(dinBad == 0, "R6", {tag, " din steady while high"}, dinBad, 0);
      chk(minHi == PHASE, "R7", {tag, " high phase"}, minHi, PHASE);
      chk(minLo >= PHASE, "R7", {tag, " low phase"}, minLo, PHASE);
      chk(endCyc - lastFallCyc == FINAL, "R9", {tag, " final wait"}, endCyc - lastFallCyc, FINAL);
      chk(doneOk == (mode == 2) && doneErr == (mode == 0), "R9", {tag, " result"},
          {doneOk, doneErr}, (mode == 2) ? 2 : 1);
    end
    chk(!(doneOk && doneErr) && (doneOk || doneErr), "R10", {tag, " flags held"},
        {doneOk, doneErr}, (mode == 2) ? 2 : 1);
    chk(progN == 1 && cclk == 0 && din == 0 && busy == 0 && inReady == 0, "R1",
        {tag, " idle lines"}, {progN, cclk, din, busy, inReady}, 5'b10000);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk(progN == 1 && cclk == 0 && din == 0 && busy == 0 && inReady == 0 &&
        doneOk == 0 && doneErr == 0, "R1", "reset state",
        {progN, cclk, din, busy, inReady, doneOk, doneErr}, 7'b1000000);
    rstN = 1;
    repeat (2) @(negedge clk);

    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'hFF; mem[3] = 8'hA5; mem[4] = 8'h3C;
    mem[5] = 8'h77; mem[6] = 8'h77;
    runLoad(5, 2, 0, 0, "basic");
    runLoad(5, 0, 0, 0, "late fail");
    runLoad(5, 1, 0, 0, "early fail");
    runLoad(5, 2, 1, 1, "restart ignored R11");

    mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h03; mem[3] = 8'hFF; mem[4] = 8'hFF;
    runLoad(3, 2, 0, 0, "no marker R5");
    runLoad(0, 2, 0, 0, "zero length R5");

    mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'h00; mem[3] = 8'hFF;
    runLoad(4, 2, 1, 0, "double marker");

    // sweep of header and payload sizes; p = 0 places the marker past the length
    for (int h = 0; h < 4; h++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < h; k++) mem[k] = 8'h11 * (k + 1);
        if (p > 0) mem[h] = 8'hFF;
        for (int j = 1; j < p; j++) mem[h + j] = 8'h5A + 8'h37 * j;
        mem[h + p] = 8'hFF;
        mem[h + p + 1] = 8'hFF;
        runLoad(h + p, 2, ((h + p) % 2) == 1, 0, $sformatf("sweep h%0d p%0d", h, p));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule